// File: doc/BRIEF.md
# Byte/Word ALU with Status Flags

A purely combinational arithmetic and logic unit for a 16-bit datapath. It takes a destination operand, a source operand, a 4-bit operation code and a width select, and returns the result, a write-back strobe and an updated 16-bit flag word. The operations are add, subtract, compare, increment, decrement, two's-complement negate, bitwise AND, OR, XOR and bitwise complement. Each can work on the low byte or on the whole word.

The incoming flag word is passed through to the output. Only the six status bits that the current operation is allowed to touch are replaced. Each operation has its own rule about which flags it updates and which it keeps. The control bits and the unused bits always come through unchanged. The surrounding pipeline writes `res_o` to the destination register when `wr_o` is high, and loads `flags_o` into its flag register.

Top module: `bwalu`

## Requirements
- R1: Operation codes are ADD=0, SUB=1, CMP=2, INC=3, DEC=4, NEG=5, AND=6, OR=7, XOR=8, NOT=9. ADD gives dst+src and SUB gives dst-src at the selected width (`word_i`=1 means 16 bits, 0 means 8 bits). CF (bit 0) is the carry out of, or the borrow into, the most significant bit of that width.
- R2: For ADD, SUB, CMP, INC, DEC and NEG, OF (bit 11) is set on signed overflow at the selected width. AF (bit 4) is the carry out of bit 3, or the borrow into bit 3.
- R3: For every operation that updates flags, ZF (bit 6) is 1 when the result at the selected width is zero. SF (bit 7) is the sign bit of the result at that width. PF (bit 2) is 1 when the low result byte holds an even number of ones.
- R4: INC gives dst+1 and DEC gives dst-1. Both update PF, AF, ZF, SF and OF and keep CF from `flags_i`.
- R5: NEG gives 0-dst. CF is 1 for a nonzero operand and 0 for a zero operand (for example, byte 15h gives EBh with CF=1).
- R6: CMP sets all six status flags exactly as SUB does for the same operands, and it holds `wr_o` low.
- R7: AND, OR and XOR give the bitwise result (for example, 61h AND CFh = 41h). They force CF, OF and AF to 0 and update ZF, SF and PF.
- R8: NOT gives the bitwise complement of dst (for example, 39h gives C6h), writes it back, and leaves all of `flags_o` equal to `flags_i`.
- R9: In byte mode, bits 15:8 of the result equal bits 15:8 of dst.
- R10: Flag bits other than 0, 2, 4, 6, 7 and 11 are always copied from `flags_i`. This includes the control bits 8, 9 and 10.
- R11: Codes 10 to 15 hold `wr_o` low, return dst as the result and leave `flags_o` equal to `flags_i`. Every code from 0 to 9 other than CMP drives `wr_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| word_i | input | 1 | 1 = word operation, 0 = byte operation |
| dst_i | input | 16 | Destination (first) operand |
| src_i | input | 16 | Source (second) operand |
| flags_i | input | 16 | Current flag word |
| res_o | output | 16 | Result value |
| wr_o | output | 1 | Result should be written back |
| flags_o | output | 16 | Updated flag word |

## Verification
The block has no registers, so every output settles in the same cycle that its inputs change, with zero cycles of latency. The bench drives new inputs just after a rising edge of its own clock. It samples `res_o`, `wr_o` and `flags_o` at the following falling edge, which is half a period later, when the inputs have long since settled. Directed corner values are checked against literal numbers. A pseudo-random sweep over all sixteen codes and both widths is compared against a reference model that the bench builds from unsigned and signed range arithmetic rather than from carry chains.

// File: rtl/bwalu_pkg.sv
package bwalu_pkg;

   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_SUB = 4'd1,
      OP_CMP = 4'd2,
      OP_INC = 4'd3,
      OP_DEC = 4'd4,
      OP_NEG = 4'd5,
      OP_AND = 4'd6,
      OP_OR  = 4'd7,
      OP_XOR = 4'd8,
      OP_NOT = 4'd9
   } alu_op_e;

   // status bit positions in the flag word (decoded by the flag register)
   localparam int FL_CF = 0;
   localparam int FL_PF = 2;
   localparam int FL_AF = 4;
   localparam int FL_ZF = 6;
   localparam int FL_SF = 7;
   localparam int FL_OF = 11;

   typedef struct packed {
      logic cf;
      logic pf;
      logic af;
      logic zf;
      logic sf;
      logic of;
   } stat_t;

endpackage

// File: rtl/bwalu_addsub.sv
module bwalu_addsub #(
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic [DATA_W-1:0] x_i,
   input  logic [DATA_W-1:0] y_i,
   input  logic              sub_i,
   input  logic              word_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              cf_o,
   output logic              af_o,
   output logic              of_o
);
   localparam int NIB_W = BYTE_W / 2;

   if (DATA_W <= BYTE_W) begin : g_bad_width
      $error("bwalu_addsub: DATA_W must exceed BYTE_W");
   end
   if (NIB_W * 2 != BYTE_W) begin : g_bad_byte
      $error("bwalu_addsub: BYTE_W must be even");
   end

   logic [DATA_W-1:0] y_eff;
   logic [DATA_W:0]   full;
   logic              c_word, c_byte, c_nib;
   logic              c_into_wmsb, c_into_bmsb;
   logic              c_out, c_into_msb;

   assign y_eff = sub_i ? ~y_i : y_i;
   assign full  = {1'b0, x_i} + {1'b0, y_eff} + {{DATA_W{1'b0}}, sub_i};

   // carry into a bit position = x ^ y ^ sum at that position
   assign c_word      = full[DATA_W];
   assign c_byte      = x_i[BYTE_W] ^ y_eff[BYTE_W] ^ full[BYTE_W];
   assign c_nib       = x_i[NIB_W] ^ y_eff[NIB_W] ^ full[NIB_W];
   assign c_into_wmsb = x_i[DATA_W-1] ^ y_eff[DATA_W-1] ^ full[DATA_W-1];
   assign c_into_bmsb = x_i[BYTE_W-1] ^ y_eff[BYTE_W-1] ^ full[BYTE_W-1];

   assign c_out      = word_i ? c_word : c_byte;
   assign c_into_msb = word_i ? c_into_wmsb : c_into_bmsb;

   assign sum_o = full[DATA_W-1:0];
   // a subtract reports a borrow, which is the inverse of the raw carry
   assign cf_o  = c_out ^ sub_i;
   assign af_o  = c_nib ^ sub_i;
   assign of_o  = c_out ^ c_into_msb;

endmodule

// File: rtl/bwalu_logic.sv
module bwalu_logic
   import bwalu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  alu_op_e           op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] y_o
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      always_comb begin
         unique case (op_i)
            OP_AND:  y_o[i] = a_i[i] & b_i[i];
            OP_OR:   y_o[i] = a_i[i] | b_i[i];
            OP_XOR:  y_o[i] = a_i[i] ^ b_i[i];
            default: y_o[i] = ~a_i[i];
         endcase
      end
   end
endmodule

// File: rtl/bwalu_flags.sv
module bwalu_flags
   import bwalu_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8,
   parameter int FLAG_W = 16
) (
   input  alu_op_e           op_i,
   input  logic              word_i,
   input  logic [DATA_W-1:0] res_i,
   input  logic              cf_i,
   input  logic              af_i,
   input  logic              of_i,
   input  logic [FLAG_W-1:0] flags_i,
   output logic [FLAG_W-1:0] flags_o
);
   if (FLAG_W <= FL_OF) begin : g_bad_flag_w
      $error("bwalu_flags: FLAG_W too narrow for the status layout");
   end

   stat_t st;
   logic  zero, sign, par;

   assign zero = word_i ? (res_i == '0) : (res_i[BYTE_W-1:0] == '0);
   assign sign = word_i ? res_i[DATA_W-1] : res_i[BYTE_W-1];
   assign par  = ~^res_i[BYTE_W-1:0];

   always_comb begin
      st.cf = flags_i[FL_CF];
      st.pf = flags_i[FL_PF];
      st.af = flags_i[FL_AF];
      st.zf = flags_i[FL_ZF];
      st.sf = flags_i[FL_SF];
      st.of = flags_i[FL_OF];
      case (op_i)
         OP_ADD, OP_SUB, OP_CMP, OP_NEG: begin
            st = '{cf: cf_i, pf: par, af: af_i, zf: zero, sf: sign, of: of_i};
         end
         OP_INC, OP_DEC: begin
            st.pf = par;
            st.af = af_i;
            st.zf = zero;
            st.sf = sign;
            st.of = of_i;
         end
         OP_AND, OP_OR, OP_XOR: begin
            st = '{cf: 1'b0, pf: par, af: 1'b0, zf: zero, sf: sign, of: 1'b0};
         end
         default: ;
      endcase
   end

   always_comb begin
      flags_o        = flags_i;
      flags_o[FL_CF] = st.cf;
      flags_o[FL_PF] = st.pf;
      flags_o[FL_AF] = st.af;
      flags_o[FL_ZF] = st.zf;
      flags_o[FL_SF] = st.sf;
      flags_o[FL_OF] = st.of;
   end
endmodule

// File: rtl/bwalu.sv
module bwalu
   import bwalu_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8,
   parameter int FLAG_W = 16
) (
   input  logic [3:0]        op_i,
   input  logic              word_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic [DATA_W-1:0] src_i,
   input  logic [FLAG_W-1:0] flags_i,
   output logic [DATA_W-1:0] res_o,
   output logic              wr_o,
   output logic [FLAG_W-1:0] flags_o
);
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   alu_op_e           op;
   logic [DATA_W-1:0] ax, ay, asum, lres, raw;
   logic              asub, acf, aaf, aof, known;

   assign op    = alu_op_e'(op_i);
   assign known = (op_i <= 4'd9);

   // operand steering for the shared adder
   always_comb begin
      ax   = dst_i;
      ay   = src_i;
      asub = 1'b0;
      case (op)
         OP_SUB, OP_CMP: asub = 1'b1;
         OP_INC:         ay = ONE;
         OP_DEC: begin   ay = ONE;   asub = 1'b1; end
         OP_NEG: begin   ax = '0; ay = dst_i; asub = 1'b1; end
         default: ;
      endcase
   end

   bwalu_addsub #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_add (
      .x_i(ax), .y_i(ay), .sub_i(asub), .word_i(word_i),
      .sum_o(asum), .cf_o(acf), .af_o(aaf), .of_o(aof)
   );

   bwalu_logic #(.DATA_W(DATA_W)) u_log (
      .op_i(op), .a_i(dst_i), .b_i(src_i), .y_o(lres)
   );

   always_comb begin
      case (op)
         OP_AND, OP_OR, OP_XOR, OP_NOT: raw = lres;
         OP_ADD, OP_SUB, OP_CMP, OP_INC, OP_DEC, OP_NEG: raw = asum;
         default: raw = dst_i;
      endcase
   end

   assign res_o = word_i ? raw : {dst_i[DATA_W-1:BYTE_W], raw[BYTE_W-1:0]};
   assign wr_o  = known && (op != OP_CMP);

   bwalu_flags #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .FLAG_W(FLAG_W)) u_flg (
      .op_i(op), .word_i(word_i), .res_i(raw),
      .cf_i(acf), .af_i(aaf), .of_i(aof),
      .flags_i(flags_i), .flags_o(flags_o)
   );

   // checks across the adder, logic unit and flag merge
   always_comb begin
      if (op == OP_CMP) begin
         p_cmp_nowrite_r6: assert (!wr_o) else $error("CMP wrote back");
      end
      if (op == OP_NOT) begin
         p_not_keeps_flags_r8: assert (flags_o == flags_i) else $error("NOT changed flags");
      end
      if (op == OP_AND || op == OP_OR || op == OP_XOR) begin
         p_logic_clears_r7: assert (!flags_o[FL_CF] && !flags_o[FL_OF] && !flags_o[FL_AF])
            else $error("logic op left CF/OF/AF set");
      end
      if (op == OP_INC || op == OP_DEC) begin
         p_incdec_cf_r4: assert (flags_o[FL_CF] == flags_i[FL_CF]) else $error("INC/DEC moved CF");
      end
      if (!word_i) begin
         p_upper_keep_r9: assert (res_o[DATA_W-1:BYTE_W] == dst_i[DATA_W-1:BYTE_W])
            else $error("byte op touched upper byte");
      end
      p_ctrl_pass_r10: assert (flags_o[10:8] == flags_i[10:8]) else $error("control flags changed");
      if (!known) begin
         p_unused_code_r11: assert (!wr_o && flags_o == flags_i && res_o == dst_i)
            else $error("unused code had an effect");
      end
      if (op == OP_NEG) begin
         p_neg_cf_r5: assert (flags_o[FL_CF] == (word_i ? (dst_i != '0) : (dst_i[BYTE_W-1:0] != '0)))
            else $error("NEG carry wrong");
      end
   end

endmodule

// File: tb/bwalu_test.sv
module bwalu_test;
   logic        clk = 1'b0;
   logic [3:0]  op = 4'd0;
   logic        word = 1'b1;
   logic [15:0] dst = 16'h0000, src = 16'h0000, fin = 16'h0000;
   logic [15:0] res, fout;
   logic        wr;
   int          total = 0, bad = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   bwalu uut (
      .op_i(op), .word_i(word), .dst_i(dst), .src_i(src), .flags_i(fin),
      .res_o(res), .wr_o(wr), .flags_o(fout)
   );

   task automatic chk(input string req, input string what, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic drive(input logic [3:0] o, input logic w, input logic [15:0] d,
                        input logic [15:0] s, input logic [15:0] f);
      @(posedge clk);
      op = o; word = w; dst = d; src = s; fin = f;
      @(negedge clk);
   endtask

   // reference model built from range arithmetic
   function automatic void model(input logic [3:0] o, input logic w, input logic [15:0] d,
                                 input logic [15:0] s, input logic [15:0] f,
                                 output logic [15:0] r, output logic we, output logic [15:0] fo);
      int mask, msb, x, y, u, sx, sy, sr, hi, lo;
      bit arith, sub, cf, af, of, lgc;
      logic [15:0] v;
      mask = w ? 32'hFFFF : 32'hFF;
      msb  = w ? 15 : 7;
      hi   = w ? 32767 : 127;
      lo   = w ? -32768 : -128;
      arith = 1; sub = 0; lgc = 0; x = d & mask; y = s & mask;
      case (o)
         4'd0: sub = 0;
         4'd1, 4'd2: sub = 1;
         4'd3: y = 1;
         4'd4: begin y = 1; sub = 1; end
         4'd5: begin y = x; x = 0; sub = 1; end
         default: arith = 0;
      endcase
      fo = f; we = (o <= 4'd9) && (o != 4'd2); v = d;
      if (arith) begin
         sx = (x > hi) ? x - mask - 1 : x;
         sy = (y > hi) ? y - mask - 1 : y;
         if (sub) begin
            u = (x - y) & mask; cf = x < y; af = (x & 15) < (y & 15); sr = sx - sy;
         end else begin
            u = (x + y) & mask; cf = (x + y) > mask; af = ((x & 15) + (y & 15)) > 15; sr = sx + sy;
         end
         of = (sr > hi) || (sr < lo);
         v = 16'(u);
         if (o != 4'd3 && o != 4'd4) fo[0] = cf;
         fo[4] = af; fo[11] = of;
      end else if (o >= 4'd6 && o <= 4'd9) begin
         case (o)
            4'd6: v = d & s;
            4'd7: v = d | s;
            4'd8: v = d ^ s;
            default: v = ~d;
         endcase
         lgc = (o != 4'd9);
         if (lgc) begin fo[0] = 0; fo[4] = 0; fo[11] = 0; end
      end
      if (arith || lgc) begin
         fo[6] = ((int'(v) & mask) == 0);
         fo[7] = v[msb];
         fo[2] = ($countones(v[7:0]) % 2) == 0;
      end
      r = w ? v : {d[15:8], v[7:0]};
   endfunction

   function automatic string req_of(input logic [3:0] o);
      case (o)
         4'd0, 4'd1: return "R1";
         4'd2: return "R6";
         4'd3, 4'd4: return "R4";
         4'd5: return "R5";
         4'd6, 4'd7, 4'd8: return "R7";
         4'd9: return "R8";
         default: return "R11";
      endcase
   endfunction

   task automatic t_idle;   // default inputs: ADD 0+0 word
      drive(4'd0, 1'b1, 16'h0, 16'h0, 16'h0);
      chk("R1", "idle result", res, 16'h0);
      chk("R3", "idle ZF/PF", {fout[6], fout[2]}, 2'b11);
      chk("R1", "idle wr", wr, 1);
   endtask

   task automatic t_byte_add_wrap;
      drive(4'd0, 1'b0, 16'hA5FF, 16'h0001, 16'h0000);
      chk("R9", "upper byte kept", res, 16'hA500);
      chk("R1", "byte carry", fout[0], 1);
      chk("R2", "byte AF", fout[4], 1);
      chk("R3", "byte ZF", fout[6], 1);
   endtask

   task automatic t_word_overflow;
      drive(4'd0, 1'b1, 16'h7FFF, 16'h0001, 16'h0000);
      chk("R2", "word OF", fout[11], 1);
      chk("R3", "word SF", fout[7], 1);
      chk("R1", "word CF clear", fout[0], 0);
      drive(4'd1, 1'b1, 16'h0003, 16'h0005, 16'h0000);
      chk("R1", "sub borrow result", res, 16'hFFFE);
      chk("R1", "sub borrow CF", fout[0], 1);
   endtask

   task automatic t_incdec_keep_cf;
      drive(4'd3, 1'b1, 16'hFFFF, 16'h0000, 16'h0000);
      chk("R4", "INC wrap result", res, 16'h0000);
      chk("R4", "INC CF kept 0", fout[0], 0);
      drive(4'd4, 1'b0, 16'h1200, 16'h0000, 16'h0001);
      chk("R4", "DEC byte result", res, 16'h12FF);
      chk("R4", "DEC CF kept 1", fout[0], 1);
   endtask

   task automatic t_neg;
      drive(4'd5, 1'b0, 16'h0015, 16'h0000, 16'h0000);
      chk("R5", "NEG 15h", res[7:0], 8'hEB);
      chk("R5", "NEG CF", fout[0], 1);
      drive(4'd5, 1'b1, 16'h0000, 16'h0000, 16'h0001);
      chk("R5", "NEG zero CF", fout[0], 0);
   endtask

   task automatic t_cmp;
      drive(4'd2, 1'b1, 16'h1234, 16'h1234, 16'h0000);
      chk("R6", "CMP no write", wr, 0);
      chk("R6", "CMP equal ZF", fout[6], 1);
   endtask

   task automatic t_logic_not;
      drive(4'd6, 1'b0, 16'h0061, 16'h00CF, 16'h0811);
      chk("R7", "AND result", res[7:0], 8'h41);
      chk("R7", "AND CF/AF/OF", {fout[11], fout[4], fout[0]}, 3'b000);
      drive(4'd9, 1'b0, 16'h0039, 16'h0000, 16'h0FD5);
      chk("R8", "NOT result", res[7:0], 8'hC6);
      chk("R8", "NOT flags", fout, 16'h0FD5);
   endtask

   task automatic t_passthru;
      drive(4'd0, 1'b1, 16'h0001, 16'h0001, 16'hF700);
      chk("R10", "control and spare bits", fout & 16'hF728, 16'hF700);
      drive(4'd12, 1'b1, 16'hBEEF, 16'h1111, 16'h0ACD);
      chk("R11", "unused code result", res, 16'hBEEF);
      chk("R11", "unused code wr", wr, 0);
      chk("R11", "unused code flags", fout, 16'h0ACD);
   endtask

   task automatic t_sweep;
      logic [15:0] er, ef;
      logic        ew;
      for (int i = 0; i < 400; i++) begin
         drive(4'(i % 16), 1'($urandom_range(0, 1)), 16'($urandom), 16'($urandom), 16'($urandom));
         model(op, word, dst, src, fin, er, ew, ef);
         chk(req_of(op), "sweep result", res, er);
         chk(req_of(op), "sweep wr", wr, ew);
         chk(req_of(op), "sweep flags R3", fout, ef);
      end
   endtask

   initial begin
      t_idle();
      t_byte_add_wrap();
      t_word_overflow();
      t_incdec_keep_cf();
      t_neg();
      t_cmp();
      t_logic_not();
      t_passthru();
      t_sweep();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule